// File: doc/BRIEF.md
# In-Application Flash Programming Controller

This block lets a processor read, program and erase a small on-chip nonvolatile byte store through a byte-wide register bus. Software loads an address, a command and, for programming, a data byte. It then writes a two-byte key sequence to a trigger register. Only then does the operation start. While the operation runs, a stall output holds the processor. A read returns the fetched byte in the data register.

The store behaves like flash. Programming can only clear bits. Erase returns a whole 512-byte sector to all ones, one byte per cycle. Latencies are parameters, and erase is the longest. An address beyond the store sets a sticky fail flag and leaves the store untouched.

Register offsets (3-bit `reg_addr`): 0 data, 1 address high byte, 2 address low byte, 3 command, 4 trigger, 5 control. Offsets 6 and 7 read zero. Control bit 7 is the enable and bit 0 is the fail flag. The command codes are 00 none, 01 read byte, 10 program byte and 11 erase sector.

Top module: `iap_flash_ctrl`

## Requirements
- R1: After reset, every readable register reads 0x00 and `cpu_stall` is low.
- R2: An operation starts only when 0x5A and then 0xA5 are written to offset 4. The reversed order, or any other value before 0xA5, starts nothing.
- R3: After 0x5A has been written, any access other than a write of 0xA5 to offset 4 returns the key tracker to idle. This includes a second 0x5A and any register read.
- R4: While control bit 7 is 0, a complete key sequence starts nothing.
- R5: A read command loads the byte at the 16-bit address {high,low} into the data register on the clock edge where `cpu_stall` falls.
- R6: A program command stores the old byte AND the data register value held when the key completes. The data register keeps that value.
- R7: An erase command sets all 512 bytes of the aligned sector that holds the address to 0xFF. It leaves the data register and every other sector unchanged.
- R8: `cpu_stall` rises on the edge that accepts the 0xA5 write and stays high for exactly READ_LAT, PROG_LAT or ERASE_LAT cycles (defaults 2, 6 and 600).
- R9: The address and command registers keep their values after an operation; nothing increments them.
- R10: Command 00 with a valid key sequence raises no stall and changes no state.
- R11: A read, program or erase at an address of DEPTH (1024) or more sets control bit 0 one edge after the key. It raises no stall and leaves the store unchanged. Writing 0 to bit 0 clears the flag.
- R12: Register writes made while `cpu_stall` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current offset (combinational) |
| cpu_stall | output | 1 | High while an operation runs |

## Verification
The stall output is due one edge after the 0xA5 write. It then stays high for the command's latency. The data register is due on the same edge where stall falls. The fail flag is due one edge after the key. The bench model updates on each rising edge from the inputs driven at the previous falling edge. It then compares the stall output and the read-back register 1 ns after that edge, so every result is checked in the cycle it becomes due. Latency checks count the falling edges on which stall is high. They expect exactly the parameter value.

// File: rtl/iap_pkg.sv
package iap_pkg;
  localparam int REG_AW = 3;
  localparam int BUS_AW = 16;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_READ  = 2'b01,
    CMD_PROG  = 2'b10,
    CMD_ERASE = 2'b11
  } iap_cmd_e;

  localparam logic [REG_AW-1:0] RA_DATA  = 3'd0;
  localparam logic [REG_AW-1:0] RA_ADDRH = 3'd1;
  localparam logic [REG_AW-1:0] RA_ADDRL = 3'd2;
  localparam logic [REG_AW-1:0] RA_CMD   = 3'd3;
  localparam logic [REG_AW-1:0] RA_TRIG  = 3'd4;
  localparam logic [REG_AW-1:0] RA_CTRL  = 3'd5;

  localparam logic [7:0] KEY_ARM  = 8'h5A;
  localparam logic [7:0] KEY_FIRE = 8'hA5;

  localparam int CTRL_EN_BIT   = 7;
  localparam int CTRL_FAIL_BIT = 0;
endpackage

// File: rtl/iap_unlock.sv
module iap_unlock
  import iap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [REG_AW-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  input  logic              enable,
  output logic              armed,
  output logic              go
);
  logic trig_wr;
  logic armed_n;
  logic arm_ce;

  assign trig_wr = acc_wr && (acc_addr == RA_TRIG);
  assign arm_ce  = acc_wr || acc_rd;

  always_comb begin
    armed_n = armed;
    go      = 1'b0;
    if (trig_wr) begin
      if (armed && (acc_wdata == KEY_FIRE)) begin
        go = enable;
      end
      armed_n = !armed && (acc_wdata == KEY_ARM);
    end else if (arm_ce) begin
      armed_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (arm_ce) begin
      armed <= armed_n;
    end
  end
endmodule

// File: rtl/iap_array.sv
module iap_array #(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/iap_seq.sv
module iap_seq
  import iap_pkg::*;
#(
  parameter int DEPTH     = 1024,
  parameter int SECTOR    = 512,
  parameter int READ_LAT  = 2,
  parameter int PROG_LAT  = 6,
  parameter int ERASE_LAT = 600,
  localparam int AW       = $clog2(DEPTH),
  localparam int SW       = $clog2(SECTOR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [1:0]        cmd,
  input  logic [BUS_AW-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [7:0]        arr_rdata,
  output logic              busy,
  output logic              rd_done,
  output logic              fail_set,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic [AW-1:0]     op_addr
);
  localparam int ERASE_CYC = (ERASE_LAT < SECTOR) ? SECTOR : ERASE_LAT;
  localparam int MAX_RP    = (READ_LAT > PROG_LAT) ? READ_LAT : PROG_LAT;
  localparam int MAX_LAT   = (MAX_RP > ERASE_CYC) ? MAX_RP : ERASE_CYC;
  localparam int CW        = $clog2(MAX_LAT + 1);

  logic          run_q, run_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [1:0]    op_cmd_q;
  logic [AW-1:0] op_addr_q;
  logic [7:0]    op_data_q;
  logic [SW:0]   sweep_q, sweep_n;
  logic          start;
  logic          in_range;
  logic [AW-1:0] erase_addr;

  function automatic logic [CW-1:0] lat_of(input logic [1:0] c);
    case (c)
      CMD_READ: lat_of = CW'(READ_LAT - 1);
      CMD_PROG: lat_of = CW'(PROG_LAT - 1);
      default:  lat_of = CW'(ERASE_CYC - 1);
    endcase
  endfunction

  assign in_range = (32'(addr) < DEPTH);

  generate
    if (AW > SW) begin : g_multi_sector
      assign erase_addr = {op_addr_q[AW-1:SW], sweep_q[SW-1:0]};
    end else begin : g_single_sector
      assign erase_addr = sweep_q[AW-1:0];
    end
  endgenerate

  always_comb begin
    run_n     = run_q;
    cnt_n     = cnt_q;
    sweep_n   = sweep_q;
    start     = 1'b0;
    rd_done   = 1'b0;
    fail_set  = 1'b0;
    mem_we    = 1'b0;
    mem_waddr = op_addr_q;
    mem_wdata = op_data_q & arr_rdata;
    if (!run_q) begin
      if (go && (cmd != CMD_NOP)) begin
        if (!in_range) begin
          fail_set = 1'b1;
        end else begin
          start   = 1'b1;
          run_n   = 1'b1;
          cnt_n   = lat_of(cmd);
          sweep_n = '0;
        end
      end
    end else begin
      if ((op_cmd_q == CMD_ERASE) && !sweep_q[SW]) begin
        mem_we    = 1'b1;
        mem_waddr = erase_addr;
        mem_wdata = 8'hFF;
        sweep_n   = sweep_q + 1'b1;
      end
      if (cnt_q == '0) begin
        run_n = 1'b0;
        if (op_cmd_q == CMD_READ) begin
          rd_done = 1'b1;
        end
        if (op_cmd_q == CMD_PROG) begin
          mem_we    = 1'b1;
          mem_waddr = op_addr_q;
          mem_wdata = op_data_q & arr_rdata;
        end
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      sweep_q <= '0;
    end else begin
      run_q   <= run_n;
      cnt_q   <= cnt_n;
      sweep_q <= sweep_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_cmd_q  <= CMD_NOP;
      op_addr_q <= '0;
      op_data_q <= '0;
    end else if (start) begin
      op_cmd_q  <= cmd;
      op_addr_q <= addr[AW-1:0];
      op_data_q <= wdata;
    end
  end

  assign busy    = run_q;
  assign op_addr = op_addr_q;
endmodule

// File: rtl/iap_flash_ctrl.sv
module iap_flash_ctrl
  import iap_pkg::*;
#(
  parameter int DEPTH     = 1024,
  parameter int SECTOR    = 512,
  parameter int READ_LAT  = 2,
  parameter int PROG_LAT  = 6,
  parameter int ERASE_LAT = 600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              cpu_stall
);
  localparam int AW = $clog2(DEPTH);

  logic          rst_meta_q, rst_sync_q;
  logic          busy;
  logic          acc_wr, acc_rd;
  logic          go, armed;
  logic          rd_done, fail_set;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, op_addr;
  logic [7:0]    mem_wdata, arr_rdata;

  logic [7:0]    data_q, data_n;
  logic [7:0]    addr_hi_q, addr_lo_q;
  logic [1:0]    cmd_q;
  logic          en_q;
  logic          fail_q, fail_n;
  logic          data_ce, ah_ce, al_ce, cmd_ce, ctrl_ce, fail_ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign acc_wr = reg_wr && !busy;
  assign acc_rd = reg_rd && !busy;

  iap_unlock u_unlock (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .acc_wr    (acc_wr),
    .acc_rd    (acc_rd),
    .acc_addr  (reg_addr),
    .acc_wdata (reg_wdata),
    .enable    (en_q),
    .armed     (armed),
    .go        (go)
  );

  iap_seq #(
    .DEPTH     (DEPTH),
    .SECTOR    (SECTOR),
    .READ_LAT  (READ_LAT),
    .PROG_LAT  (PROG_LAT),
    .ERASE_LAT (ERASE_LAT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .go        (go),
    .cmd       (cmd_q),
    .addr      ({addr_hi_q, addr_lo_q}),
    .wdata     (data_q),
    .arr_rdata (arr_rdata),
    .busy      (busy),
    .rd_done   (rd_done),
    .fail_set  (fail_set),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .op_addr   (op_addr)
  );

  iap_array #(.DEPTH(DEPTH)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (op_addr),
    .rdata (arr_rdata)
  );

  always_comb begin
    ah_ce   = acc_wr && (reg_addr == RA_ADDRH);
    al_ce   = acc_wr && (reg_addr == RA_ADDRL);
    cmd_ce  = acc_wr && (reg_addr == RA_CMD);
    ctrl_ce = acc_wr && (reg_addr == RA_CTRL);
    data_ce = (acc_wr && (reg_addr == RA_DATA)) || rd_done;
    data_n  = rd_done ? arr_rdata : reg_wdata;
    fail_ce = fail_set || ctrl_ce;
    fail_n  = fail_set ? 1'b1 : (fail_q & reg_wdata[CTRL_FAIL_BIT]);
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      data_q    <= '0;
      addr_hi_q <= '0;
      addr_lo_q <= '0;
      cmd_q     <= CMD_NOP;
      en_q      <= 1'b0;
      fail_q    <= 1'b0;
    end else begin
      if (data_ce) data_q    <= data_n;
      if (ah_ce)   addr_hi_q <= reg_wdata;
      if (al_ce)   addr_lo_q <= reg_wdata;
      if (cmd_ce)  cmd_q     <= reg_wdata[1:0];
      if (ctrl_ce) en_q      <= reg_wdata[CTRL_EN_BIT];
      if (fail_ce) fail_q    <= fail_n;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_DATA:  reg_rdata = data_q;
      RA_ADDRH: reg_rdata = addr_hi_q;
      RA_ADDRL: reg_rdata = addr_lo_q;
      RA_CMD:   reg_rdata = {6'b0, cmd_q};
      RA_CTRL:  reg_rdata = {en_q, 6'b0, fail_q};
      default:  reg_rdata = 8'h00;
    endcase
  end

  assign cpu_stall = busy;
endmodule

// File: rtl/iap_flash_chk.sv
module iap_flash_chk
  import iap_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              go,
  input logic              armed,
  input logic              acc_wr,
  input logic              acc_rd,
  input logic [REG_AW-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic [1:0]        cmd,
  input logic [15:0]       addr,
  input logic              en,
  input logic              fail,
  input logic              cpu_stall
);
  logic in_range;
  assign in_range = (32'(addr) < DEPTH);

  p_stall_on_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go && (cmd != 2'b00) && in_range |=> cpu_stall);

  p_regs_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |=> $stable(addr) && $stable(cmd));

  p_disabled_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !cpu_stall |=> !cpu_stall);

  p_nop_no_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    go && (cmd == 2'b00) |=> !cpu_stall);

  p_range_fail_r11: assert property (@(posedge clk) disable iff (!rst_n)
    go && (cmd != 2'b00) && !in_range |=> fail && !cpu_stall);

  p_read_disarms_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && acc_rd |=> !armed);

  p_bad_key_no_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && acc_wr && (reg_addr == RA_TRIG) && (reg_wdata != KEY_ARM) |=> !armed);
endmodule

bind iap_flash_ctrl iap_flash_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .go        (go),
  .armed     (armed),
  .acc_wr    (acc_wr),
  .acc_rd    (acc_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .cmd       (cmd_q),
  .addr      ({addr_hi_q, addr_lo_q}),
  .en        (en_q),
  .fail      (fail_q),
  .cpu_stall (cpu_stall)
);

// File: tb/iap_flash_ctrl_test.sv
module iap_flash_ctrl_test;
  localparam int DEPTH = 1024;
  localparam int SECT  = 512;
  localparam int RL    = 2;
  localparam int PL    = 6;
  localparam int EL    = 600;

  logic       clk;
  logic       rst_n;
  logic       reg_wr, reg_rd;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       cpu_stall;

  iap_flash_ctrl #(.DEPTH(DEPTH), .SECTOR(SECT), .READ_LAT(RL),
                   .PROG_LAT(PL), .ERASE_LAT(EL)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_stall(cpu_stall)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_mem [DEPTH];
  int m_data, m_ah, m_al, m_cmd, m_en, m_fail;
  bit m_armed;
  int m_busy, m_pcmd, m_paddr, m_pdata;

  function automatic int m_reg(input int a);
    case (a)
      0: return m_data;
      1: return m_ah;
      2: return m_al;
      3: return m_cmd;
      5: return (m_en << 7) | m_fail;
      default: return 0;
    endcase
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 'hFF;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_data = 0; m_ah = 0; m_al = 0; m_cmd = 0; m_en = 0; m_fail = 0;
      m_armed = 0; m_busy = 0;
    end else if (m_busy > 0) begin
      m_busy--;
      if (m_busy == 0) begin
        if (m_pcmd == 1) m_data = m_mem[m_paddr];
        if (m_pcmd == 2) m_mem[m_paddr] = m_mem[m_paddr] & m_pdata;
      end
    end else if (reg_wr) begin
      int a, d;
      a = int'(reg_addr);
      d = int'(reg_wdata);
      if (a == 4) begin
        if (m_armed && d == 'hA5 && m_en == 1) begin
          int fa;
          fa = m_ah * 256 + m_al;
          if (m_cmd != 0) begin
            if (fa >= DEPTH) m_fail = 1;
            else begin
              m_pcmd = m_cmd; m_paddr = fa; m_pdata = m_data;
              m_busy = (m_cmd == 1) ? RL : (m_cmd == 2) ? PL : EL;
              if (m_cmd == 3)
                for (int i = 0; i < SECT; i++) m_mem[(fa / SECT) * SECT + i] = 'hFF;
            end
          end
        end
        m_armed = !m_armed && (d == 'h5A);
      end else begin
        m_armed = 0;
        case (a)
          0: m_data = d;
          1: m_ah = d;
          2: m_al = d;
          3: m_cmd = d & 3;
          5: begin m_en = (d >> 7) & 1; m_fail = m_fail & (d & 1); end
          default: ;
        endcase
      end
    end else if (reg_rd) begin
      m_armed = 0;
    end
    #1;
    if (cmp_on) begin
      chk("R8 stall per cycle", int'(cpu_stall), int'(m_busy > 0));
      chk("R9 register readback per cycle", int'(reg_rdata), m_reg(int'(reg_addr)));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_rd = 1'b0; reg_addr = 3'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_rd = 1'b1; reg_wr = 1'b0; reg_addr = 3'(a);
    #1 v = int'(reg_rdata);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (cpu_stall) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic unlock;
    wr(4, 'h5A);
    wr(4, 'hA5);
  endtask

  task automatic run_op(input int c, input int addr, input int lat, input string tag);
    int n;
    wr(1, addr >> 8);
    wr(2, addr & 'hFF);
    wr(3, c);
    unlock();
    wait_idle(n);
    chk(tag, n, lat);
  endtask

  task automatic peek(input int addr, output int v);
    run_op(1, addr, RL, "R8 read latency");
    rd(0, v);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int v, n;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) begin rd(a, v); chk("R1 reset register", v, 0); end
    chk("R1 reset stall", int'(cpu_stall), 0);

    // enable, erase both sectors
    wr(5, 'h80);
    run_op(3, 'h0010, EL, "R8 erase latency");
    run_op(3, 'h0210, EL, "R8 erase latency");

    // R5 read of erased byte
    peek('h0123, v);
    chk("R5 read erased byte", v, 'hFF);

    // R6 program AND semantics
    wr(0, 'h3C);
    run_op(2, 'h0123, PL, "R8 program latency");
    rd(0, v); chk("R6 data register kept", v, 'h3C);
    wr(0, 'hF0);
    run_op(2, 'h0123, PL, "R8 program latency");
    peek('h0123, v); chk("R6 program ANDs", v, 'h30);
    wr(0, 'h5A);
    run_op(2, 'h0300, PL, "R8 program latency");

    // R9 registers held after operation
    rd(1, v); chk("R9 address high held", v, 'h03);
    rd(2, v); chk("R9 address low held", v, 'h00);
    rd(3, v); chk("R9 command held", v, 2);

    // R2 wrong key order or value
    wr(1, 'h01); wr(2, 'h23); wr(3, 1); wr(0, 'h77);
    wr(4, 'hA5); wr(4, 'h5A);
    @(negedge clk); chk("R2 reversed key no stall", int'(cpu_stall), 0);
    wr(4, 'h12); wr(4, 'hA5);
    @(negedge clk); chk("R2 bad first key no stall", int'(cpu_stall), 0);
    wr(4, 'hA5);
    rd(0, v); chk("R2 data untouched", v, 'h77);

    // R3 tracker reset by repeated arm or other access
    wr(4, 'h5A); wr(4, 'h5A); wr(4, 'hA5);
    @(negedge clk); chk("R3 double arm no stall", int'(cpu_stall), 0);
    wr(4, 'h5A); rd(0, v); wr(4, 'hA5);
    @(negedge clk); chk("R3 read in between no stall", int'(cpu_stall), 0);
    rd(0, v); chk("R3 data untouched", v, 'h77);

    // R4 disabled
    wr(5, 'h00);
    unlock();
    chk("R4 disabled no stall", int'(cpu_stall), 0);
    rd(0, v); chk("R4 data untouched", v, 'h77);
    wr(5, 'h80);

    // R10 no-op command
    wr(3, 0);
    unlock();
    chk("R10 nop no stall", int'(cpu_stall), 0);
    rd(0, v); chk("R10 data untouched", v, 'h77);

    // R11 out of range
    wr(0, 'h00);
    run_op(2, 'h0400, 0, "R11 program out of range no stall");
    rd(5, v); chk("R11 fail flag set", v, 'h81);
    wr(5, 'h81);
    rd(5, v); chk("R11 writing one keeps flag", v, 'h81);
    wr(5, 'h80);
    rd(5, v); chk("R11 flag cleared", v, 'h80);
    run_op(3, 'hFFFF, 0, "R11 erase out of range no stall");
    rd(5, v); chk("R11 erase fail flag", v, 'h81);
    wr(5, 'h80);
    peek('h0123, v); chk("R11 array unchanged", v, 'h30);

    // R7 erase sector 0 with data register 0x00; R12 writes during stall
    wr(0, 'h00);
    wr(1, 'h01); wr(2, 'h80); wr(3, 3);
    unlock();
    wr(0, 'h99); wr(2, 'h44);
    wait_idle(n);
    chk("R8 erase latency", n + 4, EL);
    rd(0, v); chk("R7 erase ignores data register", v, 'h00);
    rd(2, v); chk("R12 write during stall ignored", v, 'h80);
    peek('h0123, v); chk("R7 sector erased", v, 'hFF);
    peek('h01FF, v); chk("R7 sector end erased", v, 'hFF);
    peek('h0300, v); chk("R7 other sector kept", v, 'h5A);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule